// File: doc/BRIEF.md
# Test Frame Launch Control Register

This block holds the software-visible control and status word that launches a built-in self-test frame on one of two ports of a serial storage host controller. Software writes a per-port launch bit and six shared test flags. When a launch bit goes from 0 to 1, the block checks whether that port can take the request. The port must have a device attached and be in neither low-power state. If it can, the block raises a single-cycle request that carries the port number and the six flags. The request stays pending until the downstream frame builder acknowledges it.

Two completion inputs report whether the device accepted or rejected the frame. The block latches each outcome into its own sticky status bit, which software clears by writing 0. After a successful test, the port that ran it is locked out: further launches on that port are ignored until the port's enable input falls and rises again. After a rejection, software can clear the launch bit and set it again to retry, with no enable toggle. A second 32-bit register holds scratch data and has no effect on the hardware.

Top module: `bist_launch_ctrl`

## Requirements
- R1: After reset, both registers read 0x00000000 and `req_o` is low.
- R2: A request is launched only by a 0-to-1 change of a launch bit. Bit 8 launches port 0 and bit 9 launches port 1. `req_o` pulses two cycles after the write that sets the bit. Writing 1 again to a bit that is already 1 launches nothing.
- R3: A launch edge on a port is ignored unless that port's `dev_present_i` is 1, its `pm_partial_i` is 0 and its `pm_slumber_i` is 0.
- R4: A request carries the launching port on `req_port_o` and control bits 7:2 on `req_param_o`. Both outputs stay stable from the request until it is acknowledged.
- R5: `req_o` is high for exactly one cycle per request. Launch edges on either port are ignored from the request until `ack_i` is seen.
- R6: A `cpl_ok_i` pulse sets control bit 11, and a `cpl_err_i` pulse sets control bit 10. Both bits become visible on the cycle after the pulse.
- R7: Writing 0 to bit 11 or bit 10 clears that bit, and writing 1 leaves it unchanged. If a completion and a write that clears the same bit land in the same cycle, the bit ends up set.
- R8: After `cpl_ok_i`, launch edges on the port of the last request are ignored until that port's `port_en_i` goes low and then high.
- R9: After `cpl_err_i`, clearing and then setting the launch bit launches a new request with no enable toggle.
- R10: Control bits 31:12 and 1:0 always read 0, and writes to them have no effect.
- R11: The data register (`reg_sel_i`=1) reads back the last value written, resets to 0, and writing it launches no request.
- R12: If both launch bits rise in the same cycle, only port 0 is requested, and the port 1 edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the control word, 1 selects the data register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| dev_present_i | input | 2 | Device attached, one bit per port |
| pm_partial_i | input | 2 | Port in the shallow low-power state |
| pm_slumber_i | input | 2 | Port in the deep low-power state |
| port_en_i | input | 2 | Port enable, one bit per port |
| req_o | output | 1 | Single-cycle frame request |
| req_port_o | output | 1 | Port of the pending request |
| req_param_o | output | 6 | Test flags of the pending request |
| ack_i | input | 1 | Downstream acknowledge of the pending request |
| cpl_ok_i | input | 1 | Device accepted the frame |
| cpl_err_i | input | 1 | Device rejected the frame |

## Verification
The write that sets a launch bit is registered at clock edge N. The edge detector sees it during the next cycle, and the request register raises `req_o` after edge N+1. The driver pushes each expected request into a queue at the time of the write. A monitor compares the queue against `req_o` at every falling edge, so an extra pulse, a missing pulse or a pulse that lasts two cycles is reported. Status bits change one edge after a completion pulse and are read back at the following falling edge. Every rule that makes a launch "ignored" is checked by waiting several cycles and confirming that the monitor saw no request and that the request count did not move.

// File: rtl/bist_launch_pkg.sv
package bist_launch_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PARAM_W   = 6;
  localparam int unsigned PARAM_LSB = 2;
  localparam int unsigned INI_LSB   = 8;
  localparam int unsigned ERR_BIT   = 10;
  localparam int unsigned OK_BIT    = 11;
  localparam int unsigned NUM_FLAGS = 2;  // index 0: ok, 1: err
endpackage

// File: rtl/bist_port_gate.sv
module bist_port_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic present_i,
  input  logic partial_i,
  input  logic slumber_i,
  input  logic enable_i,
  input  logic lock_set_i,
  output logic want_o
);
  logic init_prev_q, en_prev_q, lock_q;
  logic rise, ready;

  assign rise   = init_i & ~init_prev_q;
  assign ready  = present_i & ~partial_i & ~slumber_i;
  assign want_o = rise & ready & ~lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_prev_q <= 1'b0;
      en_prev_q   <= 1'b0;
      lock_q      <= 1'b0;
    end else begin
      init_prev_q <= init_i;
      en_prev_q   <= enable_i;
      if (lock_set_i)                 lock_q <= 1'b1;
      else if (enable_i && !en_prev_q) lock_q <= 1'b0;  // enable re-asserted
    end
  end

  AST_GATE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    want_o |-> (present_i && !partial_i && !slumber_i)); // R3
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> !want_o); // R8
endmodule

// File: rtl/bist_status_flag.sv
module bist_status_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;          // event beats software clear
    else if (wr_i)  flag_o <= flag_o & wbit_i;
  end

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R6
  AST_FLAG_W1_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !(wr_i && !wbit_i)) |=> flag_o); // R7
endmodule

// File: rtl/bist_launch_ctrl.sv
module bist_launch_ctrl
  import bist_launch_pkg::*;
#(
  localparam int unsigned PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic                 reg_sel_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic [NUM_PORTS-1:0] dev_present_i,
  input  logic [NUM_PORTS-1:0] pm_partial_i,
  input  logic [NUM_PORTS-1:0] pm_slumber_i,
  input  logic [NUM_PORTS-1:0] port_en_i,
  output logic                 req_o,
  output logic [PW-1:0]        req_port_o,
  output logic [PARAM_W-1:0]   req_param_o,
  input  logic                 ack_i,
  input  logic                 cpl_ok_i,
  input  logic                 cpl_err_i
);
  logic                 ctrl_wr, data_wr;
  logic [PARAM_W-1:0]   param_q;
  logic [NUM_PORTS-1:0] ini_q;
  logic [REG_W-1:0]     data_q;
  logic [NUM_FLAGS-1:0] flag_set, flag_wbit, flag_q;
  logic [NUM_PORTS-1:0] want, lock_set;
  logic                 launch, launch_go, busy_q;
  logic [PW-1:0]        launch_port;

  assign ctrl_wr = reg_we_i & ~reg_sel_i;
  assign data_wr = reg_we_i &  reg_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      param_q <= '0;
      ini_q   <= '0;
      data_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        param_q <= reg_wdata_i[PARAM_LSB +: PARAM_W];
        ini_q   <= reg_wdata_i[INI_LSB +: NUM_PORTS];
      end
      if (data_wr) data_q <= reg_wdata_i;
    end
  end

  assign flag_set  = {cpl_err_i, cpl_ok_i};
  assign flag_wbit = {reg_wdata_i[ERR_BIT], reg_wdata_i[OK_BIT]};

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    bist_status_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (ctrl_wr),
      .wbit_i (flag_wbit[f]),
      .set_i  (flag_set[f]),
      .flag_o (flag_q[f])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign lock_set[p] = cpl_ok_i && (req_port_o == PW'(p));
    bist_port_gate u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .init_i     (ini_q[p]),
      .present_i  (dev_present_i[p]),
      .partial_i  (pm_partial_i[p]),
      .slumber_i  (pm_slumber_i[p]),
      .enable_i   (port_en_i[p]),
      .lock_set_i (lock_set[p]),
      .want_o     (want[p])
    );
  end

  // lowest port index wins
  always_comb begin
    launch      = 1'b0;
    launch_port = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (want[i]) begin
        launch      = 1'b1;
        launch_port = PW'(i);
      end
    end
  end

  assign launch_go = launch & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      req_o       <= 1'b0;
      req_port_o  <= '0;
      req_param_o <= '0;
    end else begin
      req_o <= launch_go;
      if (launch_go) begin
        busy_q      <= 1'b1;
        req_port_o  <= launch_port;
        req_param_o <= param_q;
      end else if (ack_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i) begin
      reg_rdata_o = data_q;
    end else begin
      reg_rdata_o[PARAM_LSB +: PARAM_W] = param_q;
      reg_rdata_o[INI_LSB +: NUM_PORTS] = ini_q;
      reg_rdata_o[OK_BIT]               = flag_q[0];
      reg_rdata_o[ERR_BIT]              = flag_q[1];
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o); // R5
  AST_REQ_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !req_o) |-> ($stable(req_port_o) && $stable(req_param_o))); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (reg_rdata_o[REG_W-1:OK_BIT+1] == '0 && reg_rdata_o[PARAM_LSB-1:0] == '0)); // R10
  AST_DATA_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !busy_q) |=> ##1 !req_o); // R11
endmodule

// File: tb/tb_bist_launch_ctrl.sv
module tb_bist_launch_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic [1:0]  dev_present_i = 2'b11, pm_partial_i = '0, pm_slumber_i = '0, port_en_i = 2'b11;
  logic        req_o, req_port_o, ack_i = 1'b0, cpl_ok_i = 1'b0, cpl_err_i = 1'b0;
  logic [5:0]  req_param_o;

  int total = 0, bad = 0, reqs_seen = 0, reqs_exp = 0;
  logic [6:0] exp_q[$];

  always #10 clk_i = ~clk_i;

  bist_launch_ctrl dut (.*);

  function automatic logic [31:0] cw(logic [5:0] p, logic [1:0] ini, logic ok, logic err);
    return {20'b0, ok, err, ini, p, 2'b00};
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // monitor: pop and compare on each request pulse
  always @(negedge clk_i) if (rst_ni && req_o) begin
    reqs_seen++;
    total++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL R5 unexpected request act=%h exp=none", {req_port_o, req_param_o});
    end else begin
      logic [6:0] e;
      e = exp_q.pop_front();
      if ({req_port_o, req_param_o} !== e) begin
        bad++;
        $display("FAIL R4 request fields act=%h exp=%h", {req_port_o, req_param_o}, e);
      end
    end
  end

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_sel_i = 1'b0;
  endtask

  task automatic expect_req(logic port, logic [5:0] p);
    exp_q.push_back({port, p});
    reqs_exp++;
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    @(negedge clk_i);
    reg_sel_i = sel;
    #1 d = reg_rdata_o;
    reg_sel_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_ack();
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0;
  endtask

  task automatic pulse_ok();
    @(negedge clk_i); cpl_ok_i = 1'b1;
    @(negedge clk_i); cpl_ok_i = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk_i); cpl_err_i = 1'b1;
    @(negedge clk_i); cpl_err_i = 1'b0;
  endtask

  task automatic count_check(string rq);
    idle(4);
    check(rq, reqs_seen, reqs_exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    logic [5:0] pa, pb;
    pa = 6'b101101; pb = 6'b010011;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1
    rd(1'b0, d); check("R1 ctrl reset", d, 32'h0);
    rd(1'b1, d); check("R1 data reset", d, 32'h0);
    check("R1 req low", {31'b0, req_o}, 32'h0);

    // R2 / R4: rising launch bit on port 0
    expect_req(1'b0, pa);
    wr(1'b0, cw(pa, 2'b01, 0, 0));
    count_check("R2 launch");
    do_ack();
    rd(1'b0, d); check("R2 readback", d, cw(pa, 2'b01, 0, 0));
    wr(1'b0, cw(pa, 2'b01, 0, 0));
    count_check("R2 level no relaunch");

    // R6 failure, R9 retry
    pulse_err();
    rd(1'b0, d); check("R6 err bit", d, cw(pa, 2'b01, 0, 1));
    wr(1'b0, cw(pa, 2'b00, 0, 1));
    expect_req(1'b0, pa);
    wr(1'b0, cw(pa, 2'b01, 0, 1));
    count_check("R9 retry after fail");
    do_ack();

    // R6 success, R8 lockout
    pulse_ok();
    rd(1'b0, d); check("R6 ok bit", d, cw(pa, 2'b01, 1, 1));
    wr(1'b0, cw(pa, 2'b00, 1, 1));
    wr(1'b0, cw(pa, 2'b01, 1, 1));
    count_check("R8 locked after success");
    @(negedge clk_i); port_en_i[0] = 1'b0;
    idle(2);
    @(negedge clk_i); port_en_i[0] = 1'b1;
    idle(2);
    wr(1'b0, cw(pa, 2'b00, 1, 1));
    expect_req(1'b0, pa);
    wr(1'b0, cw(pa, 2'b01, 1, 1));
    count_check("R8 unlocked by enable toggle");
    do_ack();

    // R7 write-0-clears, collision
    wr(1'b0, cw(pa, 2'b01, 1, 0));
    rd(1'b0, d); check("R7 w0 clear / w1 keep", d, cw(pa, 2'b01, 1, 0));
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = cw(pa, 2'b01, 1, 0); cpl_err_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; cpl_err_i = 1'b0;
    rd(1'b0, d); check("R7 completion wins", d, cw(pa, 2'b01, 1, 1));
    wr(1'b0, cw(pa, 2'b01, 0, 0));
    rd(1'b0, d); check("R7 both cleared", d, cw(pa, 2'b01, 0, 0));

    // R3 gating on port 1
    dev_present_i[1] = 1'b0;
    wr(1'b0, cw(pb, 2'b11, 0, 0));
    count_check("R3 absent device");
    dev_present_i[1] = 1'b1; pm_slumber_i[1] = 1'b1;
    wr(1'b0, cw(pb, 2'b01, 0, 0));
    wr(1'b0, cw(pb, 2'b11, 0, 0));
    count_check("R3 slumber");
    pm_slumber_i[1] = 1'b0; pm_partial_i[1] = 1'b1;
    wr(1'b0, cw(pb, 2'b01, 0, 0));
    wr(1'b0, cw(pb, 2'b11, 0, 0));
    count_check("R3 partial");
    pm_partial_i[1] = 1'b0;
    wr(1'b0, cw(pb, 2'b01, 0, 0));
    expect_req(1'b1, pb);
    wr(1'b0, cw(pb, 2'b11, 0, 0));
    count_check("R3 ready port 1 / R4 port field");
    do_ack();

    // R5 busy blocks other port
    wr(1'b0, cw(pb, 2'b00, 0, 0));
    expect_req(1'b0, pb);
    wr(1'b0, cw(pb, 2'b01, 0, 0));
    idle(3);
    wr(1'b0, cw(pb, 2'b11, 0, 0));
    count_check("R5 ignored while pending");
    do_ack();
    count_check("R5 no late launch");

    // R12 simultaneous edges
    wr(1'b0, cw(pb, 2'b00, 0, 0));
    expect_req(1'b0, pb);
    wr(1'b0, cw(pb, 2'b11, 0, 0));
    count_check("R12 port 0 priority");
    do_ack();
    count_check("R12 port 1 dropped");

    // R10 reserved bits
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); check("R10 reserved read zero", d, 32'h0000_03FC);
    count_check("R10 no launch");

    // R11 data register
    wr(1'b1, 32'hDEAD_BEEF);
    rd(1'b1, d); check("R11 data readback", d, 32'hDEAD_BEEF);
    rd(1'b0, d); check("R11 ctrl unchanged", d, 32'h0000_03FC);
    count_check("R11 no launch");

    check("R2 queue drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule